// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the architectural register store of a 32-bit processor core. Software sees sixteen general registers, numbered 0 to 15. Register 13 is the stack pointer, register 14 is the link register and register 15 is the program counter. Which physical storage element answers for a given index depends on the processor mode. The mode is held in the low five bits of the current status word. The fast-interrupt mode has its own copies of registers 8 through 12. Every exception mode keeps a private stack pointer and link register. User and System modes share a single pair.

Besides the general registers, the block holds one current status word and one saved status word for each exception mode. Two combinational read ports, one write port, a current-status port and a saved-status port are all resolved through the mode in force during the cycle. A write to the mode field therefore redirects every port from the next cycle onward. Instruction decode, flag generation and exception sequencing sit outside this block and drive its ports.

Top module: `bankreg_file`

## Requirements
- R1: After synchronous reset the current status word reads 0x000001D3: mode 10011 (Supervisor) in bits [4:0], F at bit 6, I at bit 7 and A at bit 8 all set. Every general register and every saved status word reads zero, and `mode_err` is low.
- R2: Registers 0 to 7 and register 15 are one physical copy shared by all modes. A value written in any mode reads back unchanged in every other mode.
- R3: Registers 8 to 12 select a private copy while the mode field is 10001 (fast interrupt), and the common copy in every other mode.
- R4: Registers 13 and 14 have a private copy for each of the modes 10110, 10011, 10111, 11011, 10010 and 10001. Modes 10000 (User) and 11111 (System) share one pair.
- R5: Each of the six exception modes has its own saved status word. A write in one mode is visible only in that mode.
- R6: In User or System mode the saved status port reads zero and its writes change no stored saved status word.
- R7: A mode field that matches none of the eight listed encodings selects the User bank for every port and drives `mode_err` high. Each listed encoding drives it low.
- R8: Writes take effect at the rising clock edge. A read of the index being written in the same cycle returns the old value, and both read ports return the new value from the next cycle.
- R9: A current-status write stores the full 32-bit word, including J at bit 24 and N, Z, C, V, Q at bits 31 to 27. A general or saved-status write issued in the same cycle is steered by the mode in force before that write, and the new mode selects the banks from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Architectural index for read port A |
| rd_a_data | output | DATA_W | Data from read port A |
| rd_b_idx | input | 4 | Architectural index for read port B |
| rd_b_data | output | DATA_W | Data from read port B |
| wr_en | input | 1 | General register write enable |
| wr_idx | input | 4 | Architectural index to write |
| wr_data | input | DATA_W | General register write data |
| psr_wr_en | input | 1 | Current status word write enable |
| psr_wr_data | input | 32 | New current status word |
| psr_rd_data | output | 32 | Current status word |
| spsr_wr_en | input | 1 | Saved status write enable for the current mode |
| spsr_wr_data | input | 32 | New saved status word |
| spsr_rd_data | output | 32 | Saved status word of the current mode |
| mode_err | output | 1 | Mode field holds an unlisted encoding |

## Verification
The bench builds the block with its default data width of 32. At that width the fixed status-word layout and the general registers share one word size, so every index can be checked with full-width patterns. Those patterns carry a mode tag and an index tag, and any cross-bank leak shows up as a wrong tag. The bench keeps a reference model keyed by mode. It writes distinct values in all eight valid modes and reads every index back in every mode, which covers each pair of modes for isolation. A reserved encoding and same-edge mode and data writes bring the steering corner cases within reach.

// File: rtl/bankreg_pkg.sv
package bankreg_pkg;

    localparam int STATUS_W  = 32;
    localparam int ARCH_N    = 16;
    localparam int IDX_W     = $clog2(ARCH_N);
    localparam int FIQ_LO    = 8;
    localparam int FIQ_HI    = 12;
    localparam int FIQ_N     = FIQ_HI - FIQ_LO + 1;
    localparam int EXC_BANKS = 6;
    localparam int PHYS_N    = ARCH_N + FIQ_N + 2 * EXC_BANKS;
    localparam int PIDX_W    = $clog2(PHYS_N);
    localparam int FIQ_BASE  = ARCH_N;
    localparam int EXC_BASE  = ARCH_N + FIQ_N;
    localparam int SP_IDX    = 13;

    typedef enum logic [4:0] {
        MODE_USR = 5'b10000,
        MODE_FIQ = 5'b10001,
        MODE_IRQ = 5'b10010,
        MODE_SVC = 5'b10011,
        MODE_MON = 5'b10110,
        MODE_ABT = 5'b10111,
        MODE_UND = 5'b11011,
        MODE_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        BK_USR = 3'd0,
        BK_MON = 3'd1,
        BK_SVC = 3'd2,
        BK_ABT = 3'd3,
        BK_UND = 3'd4,
        BK_IRQ = 3'd5,
        BK_FIQ = 3'd6
    } bank_e;

    typedef struct packed {
        logic        n;
        logic        z;
        logic        c;
        logic        v;
        logic        q;
        logic [1:0]  rsv_hi;
        logic        j;
        logic [13:0] rsv_mid;
        logic        e;
        logic        a;
        logic        i;
        logic        f;
        logic        t;
        logic [4:0]  mode;
    } status_t;

    typedef struct packed {
        bank_e bank;
        logic  bad;
    } mode_sel_t;

    function automatic status_t status_reset();
        status_t s;
        s      = '0;
        s.mode = MODE_SVC;
        s.a    = 1'b1;
        s.i    = 1'b1;
        s.f    = 1'b1;
        return s;
    endfunction

    function automatic mode_sel_t decode_mode(input logic [4:0] m);
        mode_sel_t r;
        r.bad = 1'b0;
        unique case (m)
            MODE_USR, MODE_SYS: r.bank = BK_USR;
            MODE_FIQ:           r.bank = BK_FIQ;
            MODE_IRQ:           r.bank = BK_IRQ;
            MODE_SVC:           r.bank = BK_SVC;
            MODE_MON:           r.bank = BK_MON;
            MODE_ABT:           r.bank = BK_ABT;
            MODE_UND:           r.bank = BK_UND;
            default: begin
                r.bank = BK_USR;
                r.bad  = 1'b1;
            end
        endcase
        return r;
    endfunction

    function automatic logic [PIDX_W-1:0] phys_index(input logic [IDX_W-1:0] idx,
                                                     input bank_e bk);
        int i;
        int p;
        i = int'(idx);
        p = i;
        if (bk == BK_FIQ && i >= FIQ_LO && i <= FIQ_HI)
            p = FIQ_BASE + (i - FIQ_LO);
        else if (bk != BK_USR && (i == SP_IDX || i == SP_IDX + 1))
            p = EXC_BASE + 2 * (int'(bk) - 1) + (i - SP_IDX);
        return PIDX_W'(p);
    endfunction

endpackage

// File: rtl/bankreg_mode_dec.sv
module bankreg_mode_dec
    import bankreg_pkg::*;
(
    input  logic [4:0] mode_field,
    output bank_e      bank,
    output logic       bad
);
    mode_sel_t sel;

    always_comb begin
        sel  = decode_mode(mode_field);
        bank = sel.bank;
        bad  = sel.bad;
    end
endmodule

// File: rtl/bankreg_gpr_array.sv
module bankreg_gpr_array #(
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 33,
    parameter int RD_PORTS = 2
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               we,
    input  logic [$clog2(ENTRIES)-1:0]         waddr,
    input  logic [DATA_W-1:0]                  wdata,
    input  logic [RD_PORTS-1:0][$clog2(ENTRIES)-1:0] raddr,
    output logic [RD_PORTS-1:0][DATA_W-1:0]    rdata
);
    localparam int AW = $clog2(ENTRIES);

    logic [DATA_W-1:0] cells [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst)
                cells[g] <= '0;
            else if (we && waddr == AW'(g))
                cells[g] <= wdata;
        end
    end

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        always_comb begin
            rdata[p] = '0;
            for (int k = 0; k < ENTRIES; k++)
                if (raddr[p] == AW'(k))
                    rdata[p] = cells[k];
        end
    end
endmodule

// File: rtl/bankreg_status.sv
module bankreg_status
    import bankreg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  bank_e               bank,
    input  logic                psr_we,
    input  logic [STATUS_W-1:0] psr_wdata,
    output status_t             psr_q,
    input  logic                spsr_we,
    input  logic [STATUS_W-1:0] spsr_wdata,
    output logic [STATUS_W-1:0] spsr_rdata
);
    logic [STATUS_W-1:0] saved [EXC_BANKS];

    always_ff @(posedge clk) begin
        if (rst)
            psr_q <= status_reset();
        else if (psr_we)
            psr_q <= status_t'(psr_wdata);
    end

    for (genvar g = 0; g < EXC_BANKS; g++) begin : g_saved
        localparam bank_e OWNER = bank_e'(3'(g + 1));
        always_ff @(posedge clk) begin
            if (rst)
                saved[g] <= '0;
            else if (spsr_we && bank == OWNER)
                saved[g] <= spsr_wdata;
        end
    end

    always_comb begin
        spsr_rdata = '0;
        for (int k = 0; k < EXC_BANKS; k++)
            if (bank == bank_e'(3'(k + 1)))
                spsr_rdata = saved[k];
    end
endmodule

// File: rtl/bankreg_file.sv
module bankreg_file
    import bankreg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [IDX_W-1:0]    rd_a_idx,
    output logic [DATA_W-1:0]   rd_a_data,
    input  logic [IDX_W-1:0]    rd_b_idx,
    output logic [DATA_W-1:0]   rd_b_data,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                psr_wr_en,
    input  logic [STATUS_W-1:0] psr_wr_data,
    output logic [STATUS_W-1:0] psr_rd_data,
    input  logic                spsr_wr_en,
    input  logic [STATUS_W-1:0] spsr_wr_data,
    output logic [STATUS_W-1:0] spsr_rd_data,
    output logic                mode_err
);
    localparam int RD_PORTS = 2;

    status_t                               psr_q;
    bank_e                                 cur_bank;
    logic                                  cur_bad;
    logic [RD_PORTS-1:0][IDX_W-1:0]        rd_idx;
    logic [RD_PORTS-1:0][PIDX_W-1:0]       rd_phys;
    logic [RD_PORTS-1:0][DATA_W-1:0]       rd_val;
    logic [PIDX_W-1:0]                     wr_phys;

    bankreg_mode_dec u_dec (
        .mode_field (psr_q.mode),
        .bank       (cur_bank),
        .bad        (cur_bad)
    );

    assign rd_idx[0] = rd_a_idx;
    assign rd_idx[1] = rd_b_idx;

    for (genvar p = 0; p < RD_PORTS; p++) begin : g_xlate
        assign rd_phys[p] = phys_index(rd_idx[p], cur_bank);
    end
    assign wr_phys = phys_index(wr_idx, cur_bank);

    bankreg_gpr_array #(
        .DATA_W   (DATA_W),
        .ENTRIES  (PHYS_N),
        .RD_PORTS (RD_PORTS)
    ) u_gpr (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_phys),
        .wdata (wr_data),
        .raddr (rd_phys),
        .rdata (rd_val)
    );

    bankreg_status u_status (
        .clk        (clk),
        .rst        (rst),
        .bank       (cur_bank),
        .psr_we     (psr_wr_en),
        .psr_wdata  (psr_wr_data),
        .psr_q      (psr_q),
        .spsr_we    (spsr_wr_en),
        .spsr_wdata (spsr_wr_data),
        .spsr_rdata (spsr_rd_data)
    );

    assign rd_a_data   = rd_val[0];
    assign rd_b_data   = rd_val[1];
    assign psr_rd_data = psr_q;
    assign mode_err    = cur_bad;
endmodule

// File: rtl/bankreg_file_checker.sv
module bankreg_file_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic              wr_en,
    input logic [3:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data,
    input logic              psr_wr_en,
    input logic [31:0]       psr_wr_data,
    input logic [31:0]       psr_rd_data,
    input logic              spsr_wr_en,
    input logic [31:0]       spsr_wr_data,
    input logic [31:0]       spsr_rd_data,
    input logic              mode_err
);
    logic [4:0] m;
    logic       listed;
    logic       plain_user;
    logic       seen_clk;

    assign m = psr_rd_data[4:0];
    assign plain_user = (m == 5'b10000) || (m == 5'b11111);
    assign listed = plain_user || (m == 5'b10001) || (m == 5'b10010) ||
                    (m == 5'b10011) || (m == 5'b10110) || (m == 5'b10111) ||
                    (m == 5'b11011);

    always_ff @(posedge clk) seen_clk <= 1'b1;

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        (seen_clk && $past(rst)) |-> (psr_rd_data == 32'h0000_01D3));

    assert_gpr_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !psr_wr_en) |=>
            ((rd_a_idx != $past(wr_idx)) || (rd_a_data == $past(wr_data))));

    assert_spsr_user_zero_R6: assert property (@(posedge clk) disable iff (rst)
        plain_user |-> (spsr_rd_data == 32'h0));

    assert_spsr_write_R5: assert property (@(posedge clk) disable iff (rst)
        (spsr_wr_en && !psr_wr_en && listed && !plain_user) |=>
            (spsr_rd_data == $past(spsr_wr_data)));

    assert_mode_err_R7: assert property (@(posedge clk) disable iff (rst)
        mode_err == !listed);

    assert_psr_store_R9: assert property (@(posedge clk) disable iff (rst)
        psr_wr_en |=> (psr_rd_data == $past(psr_wr_data)));
endmodule

bind bankreg_file bankreg_file_checker #(.DATA_W(DATA_W)) u_checker (
    .clk          (clk),
    .rst          (rst),
    .rd_a_idx     (rd_a_idx),
    .rd_a_data    (rd_a_data),
    .wr_en        (wr_en),
    .wr_idx       (wr_idx),
    .wr_data      (wr_data),
    .psr_wr_en    (psr_wr_en),
    .psr_wr_data  (psr_wr_data),
    .psr_rd_data  (psr_rd_data),
    .spsr_wr_en   (spsr_wr_en),
    .spsr_wr_data (spsr_wr_data),
    .spsr_rd_data (spsr_rd_data),
    .mode_err     (mode_err)
);

// File: tb/bankreg_file_test.sv
`timescale 1ns/1ps
module bankreg_file_test;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
    logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
    logic          wr_en = 1'b0, psr_wr_en = 1'b0, spsr_wr_en = 1'b0;
    logic [31:0]   psr_wr_data = '0, psr_rd_data, spsr_wr_data = '0, spsr_rd_data;
    logic          mode_err;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bankreg_file #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
        .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data), .psr_rd_data(psr_rd_data),
        .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data), .spsr_rd_data(spsr_rd_data),
        .mode_err(mode_err)
    );

    localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                           M_SVC = 5'b10011, M_MON = 5'b10110, M_ABT = 5'b10111,
                           M_UND = 5'b11011, M_SYS = 5'b11111;
    logic [4:0] modes [8] = '{M_USR, M_FIQ, M_IRQ, M_SVC, M_MON, M_ABT, M_UND, M_SYS};

    // reference model keyed by storage slot
    logic [31:0] mdl [256];
    logic [31:0] mdl_spsr [8];
    logic [4:0]  cur_mode;

    function automatic int bank_of(input logic [4:0] m);
        case (m)
            M_FIQ: return 1;
            M_IRQ: return 2;
            M_SVC: return 3;
            M_MON: return 4;
            M_ABT: return 5;
            M_UND: return 6;
            default: return 0;
        endcase
    endfunction

    function automatic int slot(input int idx, input logic [4:0] m);
        int b = bank_of(m);
        if (idx >= 8 && idx <= 12 && b == 1) return 100 + idx;
        if ((idx == 13 || idx == 14) && b != 0) return 200 + 2 * b + (idx - 13);
        return idx;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [4:0] m);
        @(negedge clk);
        psr_wr_en = 1'b1;
        psr_wr_data = 32'h0000_01C0 | 32'(m);
        @(posedge clk); #1;
        psr_wr_en = 1'b0;
        cur_mode = m;
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        mdl[slot(idx, cur_mode)] = d;
    endtask

    task automatic rd_a(input int idx, output logic [31:0] d);
        @(negedge clk);
        rd_a_idx = 4'(idx);
        #1 d = rd_a_data;
    endtask

    task automatic rd_b(input int idx, output logic [31:0] d);
        @(negedge clk);
        rd_b_idx = 4'(idx);
        #1 d = rd_b_data;
    endtask

    task automatic wr_spsr(input logic [31:0] d);
        @(negedge clk);
        spsr_wr_en = 1'b1; spsr_wr_data = d;
        @(posedge clk); #1;
        spsr_wr_en = 1'b0;
        if (bank_of(cur_mode) != 0) mdl_spsr[bank_of(cur_mode)] = d;
    endtask

    task automatic test_reset();
        logic [31:0] d;
        @(negedge clk);
        chk(psr_rd_data == 32'h0000_01D3, "R1 status", psr_rd_data, 32'h0000_01D3);
        chk(spsr_rd_data == 0, "R1 saved", spsr_rd_data, 0);
        chk(mode_err == 1'b0, "R1 mode_err", 32'(mode_err), 0);
        for (int i = 0; i < 16; i++) begin
            rd_a(i, d);
            chk(d == 0, "R1 gpr", d, 0);
        end
        cur_mode = M_SVC;
        for (int k = 0; k < 256; k++) mdl[k] = '0;
        for (int k = 0; k < 8; k++) mdl_spsr[k] = '0;
    endtask

    task automatic test_shared();
        logic [31:0] d;
        set_mode(M_SVC);
        for (int i = 0; i < 8; i++) wr(i, 32'hA500_0000 | 32'(i));
        wr(15, 32'hA500_000F);
        set_mode(M_FIQ);
        wr(5, 32'h5A5A_0005);
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            for (int i = 0; i < 8; i++) begin
                rd_b(i, d);
                chk(d == mdl[i], "R2 low shared", d, mdl[i]);
            end
            rd_b(15, d);
            chk(d == 32'hA500_000F, "R2 pc shared", d, 32'hA500_000F);
        end
    endtask

    task automatic test_isolation();
        logic [31:0] d, e;
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            for (int i = 8; i < 15; i++)
                wr(i, 32'hC000_0000 | (32'(i) << 8) | 32'(modes[mi]));
        end
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            for (int i = 8; i < 13; i++) begin
                rd_a(i, d);
                e = mdl[slot(i, modes[mi])];
                chk(d == e, "R3 fiq high regs", d, e);
            end
            for (int i = 13; i < 15; i++) begin
                rd_a(i, d);
                e = mdl[slot(i, modes[mi])];
                chk(d == e, "R4 sp lr bank", d, e);
                rd_b(i, d);
                chk(d == e, "R4 sp lr port b", d, e);
            end
        end
    endtask

    task automatic test_saved();
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            if (bank_of(modes[mi]) != 0) wr_spsr(32'h5500_0000 | 32'(mi));
        end
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            @(negedge clk);
            chk(spsr_rd_data == mdl_spsr[bank_of(modes[mi])], "R5 saved per mode",
                spsr_rd_data, mdl_spsr[bank_of(modes[mi])]);
        end
    endtask

    task automatic test_saved_user();
        set_mode(M_USR);
        wr_spsr(32'hDEAD_BEEF);
        @(negedge clk);
        chk(spsr_rd_data == 0, "R6 user saved reads zero", spsr_rd_data, 0);
        set_mode(M_SYS);
        wr_spsr(32'hFEED_F00D);
        @(negedge clk);
        chk(spsr_rd_data == 0, "R6 system saved reads zero", spsr_rd_data, 0);
        for (int mi = 1; mi < 7; mi++) begin
            set_mode(modes[mi]);
            @(negedge clk);
            chk(spsr_rd_data == mdl_spsr[bank_of(modes[mi])], "R6 no stray write",
                spsr_rd_data, mdl_spsr[bank_of(modes[mi])]);
        end
    endtask

    task automatic test_reserved();
        logic [31:0] d;
        for (int mi = 0; mi < 8; mi++) begin
            set_mode(modes[mi]);
            @(negedge clk);
            chk(mode_err == 1'b0, "R7 listed mode no error", 32'(mode_err), 0);
        end
        set_mode(5'b10100);
        @(negedge clk);
        chk(mode_err == 1'b1, "R7 reserved error", 32'(mode_err), 1);
        chk(spsr_rd_data == 0, "R7 reserved saved zero", spsr_rd_data, 0);
        rd_a(13, d);
        chk(d == mdl[13], "R7 reserved uses user sp", d, mdl[13]);
        rd_a(9, d);
        chk(d == mdl[9], "R7 reserved uses common r9", d, mdl[9]);
        set_mode(5'b00000);
        @(negedge clk);
        chk(mode_err == 1'b1, "R7 reserved zero error", 32'(mode_err), 1);
    endtask

    task automatic test_same_cycle();
        logic [31:0] old;
        set_mode(M_IRQ);
        old = mdl[3];
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'h1234_5678;
        rd_a_idx = 4'd3; rd_b_idx = 4'd3;
        #1;
        chk(rd_a_data == old, "R8 same cycle old a", rd_a_data, old);
        chk(rd_b_data == old, "R8 same cycle old b", rd_b_data, old);
        @(posedge clk); #1;
        wr_en = 1'b0;
        mdl[3] = 32'h1234_5678;
        @(negedge clk);
        chk(rd_a_data == 32'h1234_5678, "R8 new value a", rd_a_data, 32'h1234_5678);
        chk(rd_b_data == 32'h1234_5678, "R8 new value b", rd_b_data, 32'h1234_5678);
    endtask

    task automatic test_switch();
        logic [31:0] d, e;
        set_mode(M_SVC);
        @(negedge clk);
        psr_wr_en = 1'b1; psr_wr_data = 32'hF900_02D7; // N Z C V Q, J, E, I, F, mode ABT
        wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h0BAD_5EED;
        spsr_wr_en = 1'b1; spsr_wr_data = 32'h7777_0001;
        @(posedge clk); #1;
        psr_wr_en = 1'b0; wr_en = 1'b0; spsr_wr_en = 1'b0;
        mdl[slot(13, M_SVC)] = 32'h0BAD_5EED;
        mdl_spsr[bank_of(M_SVC)] = 32'h7777_0001;
        cur_mode = M_ABT;
        @(negedge clk);
        chk(psr_rd_data == 32'hF900_02D7, "R9 full word stored", psr_rd_data, 32'hF900_02D7);
        chk(spsr_rd_data == mdl_spsr[bank_of(M_ABT)], "R9 saved steered by old mode",
            spsr_rd_data, mdl_spsr[bank_of(M_ABT)]);
        rd_a(13, d);
        e = mdl[slot(13, M_ABT)];
        chk(d == e, "R9 new bank next cycle", d, e);
        set_mode(M_SVC);
        rd_a(13, d);
        chk(d == 32'h0BAD_5EED, "R9 write steered by old mode", d, 32'h0BAD_5EED);
        @(negedge clk);
        chk(spsr_rd_data == 32'h7777_0001, "R9 saved in old mode", spsr_rd_data, 32'h7777_0001);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        test_reset();
        test_shared();
        test_isolation();
        test_saved();
        test_saved_user();
        test_reserved();
        test_same_cycle();
        test_switch();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule